// File: doc/BRIEF.md
# Flux Transition Interval Capture Engine

This block captures raw read data from a floppy drive as a stream of time intervals. A synchronized flux input is watched for rising transitions. Each interval between two transitions is counted in sample ticks and stored as one byte in an internal RAM buffer. A single hidden address counter selects the buffer byte. The capture engine and the host both use this counter, so a host can append an end-of-track marker directly after the last captured interval.

The host reaches the block through eight byte-wide register offsets with one-cycle read and write strobes. Read data is registered and is valid in the cycle after the strobe. Offset 0 is an autoincrementing data port. Offset 1 clears the counter on a read and halts capture on a write. Offset 2 drives the drive-control lines on a write and returns two status inputs on a read. Offset 3 reaches a 16-entry configuration bit bank. A read of offset 7 starts capture. An index input can optionally insert markers into the stream. All other offsets read as zero and ignore writes.

A three-state machine controls capture:
- `ST_IDLE` waits for a start and accepts host data transfers.
- `ST_ARM` lasts one cycle and clears the interval counter and the tick phase.
- `ST_CAPTURE` stores intervals.

The transitions are:
- IDLE→ARM on a start read.
- ARM→CAPTURE unconditionally.
- any state→IDLE on a stop write.

Top module: `fluxcap_top`

## Requirements
- R1: After reset, motor_n=2'b11, select_n=2'b11, head_sel=1, dir_out=0, step_out=0 and host_rdata=0, and every configuration bit reads 1.
- R2: In ST_IDLE, each host read or write at offset 0 transfers the buffer byte at the counter, then adds one to the counter. Read data appears on host_rdata one cycle after the strobe.
- R3: A host read of offset 1 sets the counter to 0.
- R4: A host read of offset 7 in ST_IDLE starts capture. Each rising flux transition then stores the number of sample ticks since the previous transition, with bit 7 = 0, at the counter and advances the counter.
- R5: If the tick count reaches 127 with no transition, 127 is stored and counting restarts. An interval of T ticks therefore becomes floor(T/127) bytes of 127 followed by the remainder, and the remainder is omitted when it is 0.
- R6: A host write to offset 1 returns to ST_IDLE without changing the counter. Later transitions store nothing, so a 0x80 written at offset 0 lands directly after the last captured byte.
- R7: A host write to offset 2 drives the control lines from the written byte:
  - motor_n[1] ← bit 7 and motor_n[0] ← bit 3.
  - select_n[0] ← bit 5 and select_n[1] ← bit 4.
  - head_sel ← bit 2, where 1 selects head 0.
  - dir_out ← bit 1, where 1 means outward.
  - step_out ← bit 0, active high.
- R8: A host read of offset 2 returns dskchg_n in bit 5 and trk0_n in bit 4, with all other bits 0.
- R9: A host write to offset 3 stores wdata bit 7 into configuration bit number (counter mod 16). A read of offset 3 returns that bit in bit 7 with the other bits 0. Neither access moves the counter.
- R10: Configuration bit 0 = 0 selects one sample tick per clock. Bit 0 = 1 selects one tick every second clock.
- R11: Configuration bit 2 = 1 stores 0x80 for each index rising edge, and the byte is placed between intervals without altering their values. Bit 2 = 0 keeps index edges out of the stream.
- R12: The counter wraps from 2^ADDR_W−1 to 0.
- R13: In ST_ARM and ST_CAPTURE, host accesses at offset 0 transfer nothing and leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock and fast sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| flux_in | input | 1 | Raw flux pulse train, active high |
| index_in | input | 1 | Raw index pulse, active high |
| dskchg_n | input | 1 | Disk-change status, active low |
| trk0_n | input | 1 | Track-zero status, active low |
| motor_n | output | 2 | Motor enables, active low |
| select_n | output | 2 | Drive selects, active low |
| head_sel | output | 1 | 1 selects head 0 |
| dir_out | output | 1 | Step direction, 1 outward |
| step_out | output | 1 | Step pulse, active high |

## Verification
Capture is exercised with pulse trains in several forms:
- Spacings from 2 to 300 cycles in fast mode. These separate the minimal and mid-range intervals from the 127, 128, 254 and 300 spacings that exercise saturation splitting.
- Even spacings in slow mode. These show that the stored counts halve, which tells the tick selection apart from the cycle count.
- Index pulses placed inside gaps, once with index marking on and once with it off. These show whether the marker is inserted without disturbing the surrounding intervals.
- Data-port traffic during capture and transitions after a stop. The 0x80 readback marker must then follow the captured bytes directly, so any stray write or increment shows up as a shifted stream.

// File: rtl/fluxcap_pkg.sv
package fluxcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_CAPTURE = 2'd2
    } cap_state_e;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_CTRL  = 3'd1;
    localparam logic [2:0] OFS_DRIVE = 3'd2;
    localparam logic [2:0] OFS_CFG   = 3'd3;
    localparam logic [2:0] OFS_START = 3'd7;

    localparam int CFG_SLOW_BIT  = 0;
    localparam int CFG_INDEX_BIT = 2;

    localparam logic [7:0] MARK_BYTE = 8'h80;
endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sig_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fc_ctrl_fsm.sv
module fc_ctrl_fsm
    import fluxcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    output cap_state_e state_o,
    output logic       arm_o,
    output logic       active_o
);
    cap_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_req) state_d = ST_ARM;
            ST_ARM:     state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_CAPTURE;
            default:    state_d = ST_IDLE;
        endcase
        if (stop_req) state_d = ST_IDLE;
    end

    always_comb begin
        arm_o    = 1'b0;
        active_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ARM:     arm_o = 1'b1;
            ST_CAPTURE: active_o = 1'b1;
            default:    ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/fc_interval.sv
module fc_interval
    import fluxcap_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic           active_i,
    input  logic           slow_i,
    input  logic           flux_edge_i,
    input  logic           idx_edge_i,
    input  logic           idx_en_i,
    output logic           store_o,
    output logic [CNT_W:0] data_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             pend_q, pend_d;
    logic             phase_q;
    logic             tick;

    always_comb begin
        tick    = slow_i ? phase_q : 1'b1;
        cnt_inc = cnt_q + CNT_W'(tick);
        store_o = 1'b0;
        data_o  = '0;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        if (active_i) begin
            cnt_d = cnt_inc;
            if (flux_edge_i) begin
                store_o = 1'b1;
                data_o  = {1'b0, cnt_inc};
                cnt_d   = '0;
            end else if (cnt_inc == CNT_MAX) begin
                store_o = 1'b1;
                data_o  = {1'b0, CNT_MAX};
                cnt_d   = '0;
            end else if (pend_q) begin
                store_o = 1'b1;
                data_o  = (CNT_W+1)'(MARK_BYTE);
                pend_d  = 1'b0;
            end
            if (idx_edge_i && idx_en_i) pend_d = 1'b1;
        end else begin
            cnt_d  = '0;
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            phase_q <= ~phase_q;
        end
    end
endmodule

// File: rtl/fc_buffer.sv
module fc_buffer #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
        if (re_i) rdata_o <= mem[addr_i];
    end
endmodule

// File: rtl/fluxcap_top.sv
module fluxcap_top
    import fluxcap_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int CFG_W       = 16,
    parameter int CNT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_addr,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       flux_in,
    input  logic       index_in,
    input  logic       dskchg_n,
    input  logic       trk0_n,
    output logic [1:0] motor_n,
    output logic [1:0] select_n,
    output logic       head_sel,
    output logic       dir_out,
    output logic       step_out
);
    localparam int IDX_W  = $clog2(CFG_W);
    localparam int DATA_W = CNT_W + 1;

    cap_state_e        state;
    logic              arm, active;
    logic [ADDR_W-1:0] addr_q;
    logic [CFG_W-1:0]  cfg_q;
    logic              flux_rise, idx_rise;
    logic              cap_we;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] buf_rdata;
    logic              host_idle, data_acc, start_req, stop_req, clear_req;
    logic              buf_we;
    logic [DATA_W-1:0] buf_wdata;
    logic              from_mem_q;
    logic [7:0]        other_q;
    logic              cfg_bit;

    assign host_idle = (state == ST_IDLE);
    assign data_acc  = (host_rd || host_wr) && (host_addr == OFS_DATA) && host_idle;
    assign start_req = host_rd && (host_addr == OFS_START) && host_idle;
    assign stop_req  = host_wr && (host_addr == OFS_CTRL);
    assign clear_req = host_rd && (host_addr == OFS_CTRL);
    assign cfg_bit   = cfg_q[addr_q[IDX_W-1:0]];

    fc_edge_sync #(.STAGES(SYNC_STAGES)) flux_sync_i (
        .clk(clk), .rst_n(rst_n), .sig_i(flux_in), .rise_o(flux_rise)
    );

    fc_edge_sync #(.STAGES(SYNC_STAGES)) index_sync_i (
        .clk(clk), .rst_n(rst_n), .sig_i(index_in), .rise_o(idx_rise)
    );

    fc_ctrl_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .state_o(state), .arm_o(arm), .active_o(active)
    );

    fc_interval #(.CNT_W(CNT_W)) interval_i (
        .clk(clk), .rst_n(rst_n), .clear_i(arm), .active_i(active),
        .slow_i(cfg_q[CFG_SLOW_BIT]), .flux_edge_i(flux_rise),
        .idx_edge_i(idx_rise), .idx_en_i(cfg_q[CFG_INDEX_BIT]),
        .store_o(cap_we), .data_o(cap_data)
    );

    assign buf_we    = cap_we || (host_wr && data_acc);
    assign buf_wdata = cap_we ? cap_data : DATA_W'(host_wdata);

    fc_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) buffer_i (
        .clk(clk), .addr_i(addr_q), .we_i(buf_we), .wdata_i(buf_wdata),
        .re_i(host_rd && data_acc), .rdata_o(buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  addr_q <= '0;
        else if (clear_req)          addr_q <= '0;
        else if (cap_we || data_acc) addr_q <= addr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '1;
        else if (host_wr && host_addr == OFS_CFG)
            cfg_q[addr_q[IDX_W-1:0]] <= host_wdata[7];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            motor_n  <= 2'b11;
            select_n <= 2'b11;
            head_sel <= 1'b1;
            dir_out  <= 1'b0;
            step_out <= 1'b0;
        end else if (host_wr && host_addr == OFS_DRIVE) begin
            motor_n  <= {host_wdata[7], host_wdata[3]};
            select_n <= {host_wdata[4], host_wdata[5]};
            head_sel <= host_wdata[2];
            dir_out  <= host_wdata[1];
            step_out <= host_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_mem_q <= 1'b0;
            other_q    <= '0;
        end else if (host_rd) begin
            from_mem_q <= data_acc;
            unique case (host_addr)
                OFS_DRIVE: other_q <= {2'b00, dskchg_n, trk0_n, 4'b0000};
                OFS_CFG:   other_q <= {cfg_bit, 7'b0};
                default:   other_q <= '0;
            endcase
        end
    end

    assign host_rdata = from_mem_q ? 8'(buf_rdata) : other_q;
endmodule

// File: rtl/fluxcap_checker.sv
module fluxcap_checker
    import fluxcap_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input cap_state_e        state,
    input logic [ADDR_W-1:0] addr_q,
    input logic              cap_we,
    input logic [7:0]        cap_data
);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && host_addr == OFS_DATA && state == ST_IDLE)
        |=> addr_q == ADDR_W'($past(addr_q) + 1));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_CTRL) |=> addr_q == '0);

    assert_capture_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> state == ST_CAPTURE);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> (!cap_data[7] || cap_data == MARK_BYTE));

    assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && host_addr == OFS_CTRL && !cap_we)
        |=> (state == ST_IDLE && $stable(addr_q)));

    assert_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && host_addr == OFS_DATA && state != ST_IDLE && !cap_we)
        |=> $stable(addr_q));
endmodule

bind fluxcap_top fluxcap_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .state(state), .addr_q(addr_q), .cap_we(cap_we),
    .cap_data(cap_data)
);

// File: tb/fluxcap_top_tb_top.sv
`timescale 1ns/1ps
module fluxcap_top_tb_top;
    localparam int DEPTH = 1 << 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       flux_in = 1'b0, index_in = 1'b0;
    logic       dskchg_n = 1'b1, trk0_n = 1'b1;
    logic [1:0] motor_n, select_n;
    logic       head_sel, dir_out, step_out;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    bit slow_mode = 1'b0;
    bit idx_mode  = 1'b0;

    always #2 clk = ~clk;

    fluxcap_top dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic set_cfg(input int idx, input bit v);
        logic [7:0] d;
        host_read(3'd1, d);
        for (int i = 0; i < idx; i++) host_read(3'd0, d);
        host_write(3'd3, v ? 8'h80 : 8'h00);
    endtask

    // driver: expected interval bytes (R4, R5)
    task automatic push_ticks(input int t);
        while (t > 127) begin
            exp_q.push_back(127);
            t -= 127;
        end
        exp_q.push_back(t);
    endtask

    task automatic pulse_first();
        repeat (5) @(negedge clk);
        flux_in = 1'b1;
        @(negedge clk);
        flux_in = 1'b0;
        exp_q.push_back(-1);
    endtask

    task automatic pulse_after(input int g, input bit record);
        repeat (g - 1) @(negedge clk);
        flux_in = 1'b1;
        @(negedge clk);
        flux_in = 1'b0;
        if (record) push_ticks(slow_mode ? g / 2 : g);
    endtask

    task automatic index_pulse(input int wait_cyc);
        repeat (wait_cyc) @(negedge clk);
        index_in = 1'b1;
        @(negedge clk);
        index_in = 1'b0;
        if (idx_mode) exp_q.push_back(8'h80);
    endtask

    task automatic start_capture();
        logic [7:0] d;
        host_read(3'd1, d);
        host_read(3'd7, d);
    endtask

    task automatic stop_and_mark();
        repeat (20) @(negedge clk);
        host_write(3'd1, 8'h00);
        pulse_after(8, 1'b0);
        pulse_after(8, 1'b0);
        host_write(3'd0, 8'h80);
    endtask

    // monitor: pops expected bytes and compares them with the buffer
    task automatic drain(input string tag);
        logic [7:0] d;
        int e;
        host_read(3'd1, d);
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            host_read(3'd0, d);
            if (e < 0) check({tag, " R4 first byte bit7"}, int'(d[7]), 0);
            else       check(tag, int'(d), e);
        end
        host_read(3'd0, d);
        check("R6 end marker after last byte", int'(d), 8'h80);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        check("R1 motor_n", int'(motor_n), 3);
        check("R1 select_n", int'(select_n), 3);
        check("R1 head/dir/step", int'({head_sel, dir_out, step_out}), 4);
        check("R1 host_rdata", int'(host_rdata), 0);
        host_read(3'd3, d);
        check("R1 cfg bit0 reset", int'(d), 8'h80);

        // R7
        host_write(3'd2, 8'h47);
        check("R7 0x47 motor_n", int'(motor_n), 0);
        check("R7 0x47 select_n", int'(select_n), 0);
        check("R7 0x47 head/dir/step", int'({head_sel, dir_out, step_out}), 7);
        host_write(3'd2, 8'hA9);
        check("R7 0xA9 motor_n", int'(motor_n), 3);
        check("R7 0xA9 select_n", int'(select_n), 1);
        check("R7 0xA9 head/dir/step", int'({head_sel, dir_out, step_out}), 1);

        // R8
        dskchg_n = 1'b0; trk0_n = 1'b1;
        host_read(3'd2, d);
        check("R8 status a", int'(d), 8'h10);
        dskchg_n = 1'b1; trk0_n = 1'b0;
        host_read(3'd2, d);
        check("R8 status b", int'(d), 8'h20);

        // R2 / R3
        host_read(3'd1, d);
        host_write(3'd0, 8'h11);
        host_write(3'd0, 8'h22);
        host_write(3'd0, 8'h33);
        host_read(3'd1, d);
        host_read(3'd0, d); check("R2 byte0", int'(d), 8'h11);
        host_read(3'd0, d); check("R2 byte1", int'(d), 8'h22);
        host_read(3'd0, d); check("R2 byte2", int'(d), 8'h33);
        host_read(3'd1, d);
        host_read(3'd0, d); check("R3 cleared counter", int'(d), 8'h11);

        // R9
        set_cfg(0, 1'b0);
        host_read(3'd3, d); check("R9 cfg0 cleared", int'(d), 0);
        set_cfg(2, 1'b0);
        host_read(3'd3, d); check("R9 cfg2 cleared", int'(d), 0);
        host_read(3'd0, d);
        host_read(3'd3, d); check("R9 cfg3 still set", int'(d), 8'h80);
        host_read(3'd1, d);
        host_read(3'd3, d); check("R9 cfg0 via index 0", int'(d), 0);

        // R4 / R5 / R13 / R11 off: fast ticks, index disabled
        slow_mode = 1'b0; idx_mode = 1'b0;
        start_capture();
        pulse_first();
        pulse_after(2, 1'b1);
        pulse_after(3, 1'b1);
        pulse_after(10, 1'b1);
        fork
            pulse_after(60, 1'b1);
            index_pulse(25);
        join
        fork
            pulse_after(50, 1'b1);
            begin
                repeat (10) @(negedge clk);
                host_write(3'd0, 8'h77);
                host_read(3'd0, d);
            end
        join
        pulse_after(126, 1'b1);
        pulse_after(127, 1'b1);
        pulse_after(128, 1'b1);
        pulse_after(254, 1'b1);
        pulse_after(300, 1'b1);
        stop_and_mark();
        drain("R4 R5 R13 fast intervals");

        // R11 on
        set_cfg(2, 1'b1);
        idx_mode = 1'b1;
        start_capture();
        pulse_first();
        pulse_after(20, 1'b1);
        fork
            pulse_after(80, 1'b1);
            index_pulse(30);
        join
        pulse_after(15, 1'b1);
        fork
            pulse_after(40, 1'b1);
            index_pulse(12);
        join
        stop_and_mark();
        drain("R11 index markers");

        // R10 slow ticks
        set_cfg(2, 1'b0);
        set_cfg(0, 1'b1);
        idx_mode = 1'b0; slow_mode = 1'b1;
        start_capture();
        pulse_first();
        pulse_after(4, 1'b1);
        pulse_after(20, 1'b1);
        pulse_after(100, 1'b1);
        pulse_after(240, 1'b1);
        stop_and_mark();
        drain("R10 slow intervals");

        // R12
        host_read(3'd1, d);
        host_write(3'd0, 8'h5C);
        for (int i = 0; i < DEPTH - 1; i++) host_read(3'd0, d);
        host_read(3'd0, d);
        check("R12 counter wrap", int'(d), 8'h5C);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule